// File: doc/BRIEF.md
# Shift Unit with Saved Funnel Count

This block is the shift execution unit of a small integer core. For a 32-bit source it performs a logical left shift, a logical right shift and an arithmetic right shift. It also performs a "shift right double". This funnel shift joins two 32-bit sources into one 64-bit value and returns the low 32 bits after shifting it right.

The funnel operation carries no count of its own. It uses a 5-bit shift-count register. Every 32-bit right shift, logical or arithmetic, writes its count into this register. A compiler therefore issues a right shift first and the funnel shift after it. The count register is visible on `sc_o`. A request is given as an opcode, two operands and a count, qualified by `valid_i`. The result comes out registered, together with a one-cycle `done_o` pulse.

Top module: `shift_unit`

## Requirements
- R1: With opcode 2'b00 (left), the result is src1 shifted left by the effective count, and zeros fill the vacated low bits.
- R2: With opcode 2'b01 (logical right), the result is src1 shifted right by the effective count, and zeros fill the vacated high bits.
- R3: With opcode 2'b10 (arithmetic right), the result is src1 shifted right by the effective count, and bit 31 of src1 fills the vacated high bits.
- R4: With opcode 2'b11 (funnel), the result is bits 31:0 of {src1, src2} shifted right by the value on `sc_o` at the time of the request. `count_i` is ignored, and a saved count of 0 returns src2.
- R5: An accepted logical or arithmetic right shift loads the effective count into `sc_o`. An accepted left shift or funnel shift leaves `sc_o` unchanged.
- R6: The effective count is bits 4:0 of `count_i`, so counts of 32 or more wrap modulo 32.
- R7: `done_o` is high in exactly the cycle after an accepted request, and `result_o` is updated in that same cycle. With no request, `result_o` holds its value and `done_o` is low.
- R8: After reset, `result_o`, `done_o` and `sc_o` are all zero.
- R9: A funnel shift issued in the cycle right after a right shift uses the count that this right shift saved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation code (see R1 to R4) |
| src1_i | input | 32 | Shifted operand, or the high half for a funnel shift |
| src2_i | input | 32 | Low half for a funnel shift |
| count_i | input | 8 | Shift count; only bits 4:0 are used |
| result_o | output | 32 | Registered result |
| done_o | output | 1 | One-cycle completion pulse |
| sc_o | output | 5 | Saved shift count |

## Verification
The bench uses the default values: DATA_W of 32 and COUNT_IN_W of 8. With an 8-bit count port, random counts from 32 to 255 occur often, so the modulo-32 wrap is exercised and is not limited to one directed case. Random requests are issued back to back with occasional idle cycles. This places funnel shifts directly after right shifts and checks that the saved count is forwarded and that the result is held while idle.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  typedef enum logic [1:0] {
    OP_SLL = 2'b00,
    OP_SRL = 2'b01,
    OP_SRA = 2'b10,
    OP_SRD = 2'b11
  } shift_op_e;
endpackage

// File: rtl/shift_prep.sv
module shift_prep
  import shift_unit_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COUNT_IN_W = 8,
  localparam int CNT_W     = $clog2(DATA_W)
) (
  input  logic [1:0]            op_i,
  input  logic [DATA_W-1:0]     src1_i,
  input  logic [DATA_W-1:0]     src2_i,
  input  logic [COUNT_IN_W-1:0] count_i,
  input  logic [CNT_W-1:0]      sc_i,
  output logic [DATA_W-1:0]     hi_o,
  output logic [DATA_W-1:0]     lo_o,
  output logic [CNT_W-1:0]      amt_o,
  output logic                  rev_o,
  output logic                  sc_wr_o
);
  shift_op_e           op;
  logic [DATA_W-1:0]   src1_rev;
  logic [CNT_W-1:0]    cnt_eff;

  assign op      = shift_op_e'(op_i);
  assign cnt_eff = count_i[CNT_W-1:0];

  // left shift is done as a right shift of the bit-reversed operand
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign src1_rev[i] = src1_i[DATA_W-1-i];
  end

  always_comb begin
    hi_o    = '0;
    lo_o    = src1_i;
    amt_o   = cnt_eff;
    rev_o   = 1'b0;
    sc_wr_o = 1'b0;
    unique case (op)
      OP_SLL: begin
        lo_o  = src1_rev;
        rev_o = 1'b1;
      end
      OP_SRL: sc_wr_o = 1'b1;
      OP_SRA: begin
        hi_o    = {DATA_W{src1_i[DATA_W-1]}};
        sc_wr_o = 1'b1;
      end
      OP_SRD: begin
        hi_o  = src1_i;
        lo_o  = src2_i;
        amt_o = sc_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter #(
  parameter int DATA_W   = 32,
  localparam int CNT_W   = $clog2(DATA_W),
  localparam int WIDE_W  = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [CNT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] res_o
);
  logic [WIDE_W-1:0] stage [CNT_W+1];

  assign stage[0] = {hi_i, lo_i};

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{STEP{1'b0}}, stage[s][WIDE_W-1:STEP]} : stage[s];
  end

  assign res_o = stage[CNT_W][DATA_W-1:0];
endmodule

// File: rtl/sc_reg.sv
module sc_reg #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_val_i,
  output logic [CNT_W-1:0] sc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sc_o <= '0;
    else if (wr_en_i) sc_o <= wr_val_i;
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_unit_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COUNT_IN_W = 8,
  localparam int CNT_W     = $clog2(DATA_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [1:0]            op_i,
  input  logic [DATA_W-1:0]     src1_i,
  input  logic [DATA_W-1:0]     src2_i,
  input  logic [COUNT_IN_W-1:0] count_i,
  output logic [DATA_W-1:0]     result_o,
  output logic                  done_o,
  output logic [CNT_W-1:0]      sc_o
);
  logic [DATA_W-1:0] hi, lo, shr_res, res_fix;
  logic [CNT_W-1:0]  amt;
  logic              rev, sc_wr;

  shift_prep #(.DATA_W(DATA_W), .COUNT_IN_W(COUNT_IN_W)) u_prep (
    .op_i, .src1_i, .src2_i, .count_i,
    .sc_i(sc_o), .hi_o(hi), .lo_o(lo), .amt_o(amt), .rev_o(rev), .sc_wr_o(sc_wr)
  );

  funnel_shifter #(.DATA_W(DATA_W)) u_funnel (
    .hi_i(hi), .lo_i(lo), .amt_i(amt), .res_o(shr_res)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_unrev
    assign res_fix[i] = rev ? shr_res[DATA_W-1-i] : shr_res[i];
  end

  sc_reg #(.CNT_W(CNT_W)) u_sc (
    .clk_i, .rst_ni,
    .wr_en_i(valid_i && sc_wr),
    .wr_val_i(count_i[CNT_W-1:0]),
    .sc_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) result_o <= res_fix;
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!done_o && $stable(result_o)));
  p_sc_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_SRL || op_i == OP_SRA)) |=> sc_o == $past(count_i[CNT_W-1:0]));
  p_sc_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_SLL || op_i == OP_SRD)) |=> $stable(sc_o));
  p_srd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SRD && sc_o == '0) |=> result_o == $past(src2_i));
  p_sll_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SLL && count_i[CNT_W-1:0] == '0) |=> result_o == $past(src1_i));
  p_sra_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SRA) |=> result_o[DATA_W-1] == $past(src1_i[DATA_W-1]));
  p_srl_msb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SRL && count_i[CNT_W-1:0] != '0) |=> !result_o[DATA_W-1]);
endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] src1 = '0, src2 = '0;
  logic [7:0]  count = '0;
  logic [31:0] result;
  logic        done;
  logic [4:0]  sc;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [31:0] exp_res = '0;
  logic        exp_done = 1'b0;
  logic [4:0]  exp_sc = '0;
  string       exp_tag = "R8";

  always #10 clk = ~clk;

  shift_unit u_shift_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .src1_i(src1), .src2_i(src2), .count_i(count),
    .result_o(result), .done_o(done), .sc_o(sc)
  );

  function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] a, b,
                                        input logic [7:0] c, input logic [4:0] s);
    logic [63:0] w;
    case (o)
      2'b00:   model = a << c[4:0];
      2'b01:   model = a >> c[4:0];
      2'b10:   model = $unsigned($signed(a) >>> c[4:0]);
      default: begin w = {a, b} >> s; model = w[31:0]; end
    endcase
  endfunction

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'b00:   op_tag = "R1";
      2'b01:   op_tag = "R2";
      2'b10:   op_tag = "R3";
      default: op_tag = "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic check_outputs();
    check("R7 done", {31'b0, done}, {31'b0, exp_done});
    check("R5 sc", {27'b0, sc}, {27'b0, exp_sc});
    if (exp_done) check(exp_tag, result, exp_res);
    else          check("R7 hold", result, exp_res);
  endtask

  task automatic step(input logic v, input logic [1:0] o, input logic [31:0] a, b,
                      input logic [7:0] c, input string tag);
    @(negedge clk);
    check_outputs();
    valid = v; op = o; src1 = a; src2 = b; count = c;
    exp_done = v;
    if (v) begin
      exp_res = model(o, a, b, c, exp_sc);
      exp_tag = tag;
      if (o == 2'b01 || o == 2'b10) exp_sc = c[4:0];
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R8 result", result, 32'h0);
    check("R8 done", {31'b0, done}, 32'h0);
    check("R8 sc", {27'b0, sc}, 32'h0);
    rst_n = 1'b1;
    // directed corners
    step(1, 2'b00, 32'h8000_0001, 32'h0, 8'd0,  "R1 count0");
    step(1, 2'b00, 32'h0000_0003, 32'h0, 8'd31, "R1 count31");
    step(1, 2'b00, 32'h1234_5678, 32'h0, 8'd32, "R6 wrap32");
    step(1, 2'b01, 32'hF000_0000, 32'h0, 8'd36, "R6 wrap36");
    step(1, 2'b10, 32'h8000_0000, 32'h0, 8'd31, "R3 sign31");
    step(1, 2'b11, 32'hAAAA_5555, 32'h1234_5678, 8'd7, "R9 srd after sra");
    step(1, 2'b01, 32'hFFFF_FFFF, 32'h0, 8'd0, "R2 count0");
    step(1, 2'b11, 32'hDEAD_BEEF, 32'hCAFE_F00D, 8'd13, "R4 sc0 gives src2");
    step(1, 2'b10, 32'h7FFF_FFFF, 32'h0, 8'd255, "R3 positive wrap");
    step(1, 2'b00, 32'h0000_FFFF, 32'h0, 8'd4, "R5 sll keeps sc");
    step(1, 2'b11, 32'h0000_00FF, 32'h0F0F_0F0F, 8'd0, "R4 srd sc31");
    step(0, 2'b01, 32'h0, 32'h0, 8'd9, "R7 idle");
    step(0, 2'b00, 32'h0, 32'h0, 8'd0, "R7 idle");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] o;
      o = 2'($urandom);
      step(($urandom % 5) != 0, o, $urandom, $urandom, 8'($urandom), op_tag(o));
    end
    step(0, 2'b00, 32'h0, 32'h0, 8'd0, "R7 idle");
    @(negedge clk);
    check_outputs();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule